// File: doc/BRIEF.md
# Preloadable Microsecond Base Timer

An 8-bit up-counter that a host processor uses to generate periodic interrupts. A prescaler divides the 4 MHz system clock by four, which gives one counting step per microsecond. The host reaches the block through a byte-wide register port with an address, write data, a write strobe and combinational read data.

To program an interval, software writes a start value into the preload register and then clears the active-low run bit in the control register. The counter runs until it passes from FFh to 00h. That wrap sets a sticky interrupt flag if interrupts are enabled. The interrupt output is the flag gated by the interrupt-enable bit. Software cannot read the flag. It removes the flag by writing a 1 to bit 0 of a dedicated clear register.

Register offsets:
- C0h: preload (write) / live count (read)
- C1h: control. Bit 0 is the active-low run bit; bit 1 is the interrupt enable.
- C2h: flag clear

Top module: `base_tick_timer`

## Requirements
- R1: After reset, the count reads 00h, the control register reads 01h (stopped, interrupts masked), and the interrupt output is low.
- R2: While control bit 0 is 0, the count increases by exactly one every 4 clocks. The first step comes 4 clocks after the clock that captured the enabling write.
- R3: A write to offset C0h sets the count to the written byte on the next clock, whether the timer runs or not. Counting continues from that value.
- R4: While control bit 0 is 1, the count holds. The bit acts as a level: clearing it again restarts counting.
- R5: A step from FFh gives 00h, so a start value P reaches the wrap after 256−P steps (1 to 256 µs).
- R6: A wrap sets the interrupt flag only when control bit 1 is 1. A wrap with bit 1 at 0 leaves the flag clear.
- R7: Once set, the flag stays set until it is cleared as in R8, independent of later control writes.
- R8: A write to offset C2h with data bit 0 at 1 clears the flag. A write there with bit 0 at 0 has no effect.
- R9: The interrupt output equals the flag ANDed with control bit 1.
- R10: When a preload write and a counting step fall on the same clock, the preload value wins. The prescaler also restarts on every preload write, so the next step comes 4 clocks after it.
- R11: When a clear write and a wrap fall on the same clock, the flag stays set.
- R12: A read at C0h returns the count. A read at C1h returns {000000b, bit 1, bit 0}. Reads at every other offset, including C2h, return 00h, so the flag is never visible on the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register offset for reads and writes |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, one clock per write |
| regRdData | output | 8 | Combinational read data for regAddr |
| timerIrq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest situations to reach are the same-clock collisions: a preload landing exactly on a prescaler step, and a flag clear landing exactly on a wrap. Both depend on the hidden prescaler phase.

The stimulus reaches them by counting clocks from a preload write, because every preload restarts the prescaler at a known phase. After a preload of FFh, the wrap falls exactly four clocks later, so a clear or a second preload can be placed on that clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int CNT_W = 8;

  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic             load;
    logic             tick;
    logic [CNT_W-1:0] loadData;
  } tmr_strobe_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             wrapHit
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  // A step from the top value is a wrap unless a preload overrides it
  assign wrapHit = strobe.tick && !strobe.load && (count == MAX_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (strobe.load)
      count <= strobe.loadData;
    else if (strobe.tick)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int                PRESCALE    = 4,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PRELOAD_OFS = 8'hC0,
  parameter logic [ADDR_W-1:0] CTRL_OFS    = 8'hC1,
  parameter logic [ADDR_W-1:0] CLEAR_OFS   = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrapHit,
  output tmr_strobe_t       strobe,
  output logic [CNT_W-1:0]  regRdData,
  output logic              runOn,
  output logic              irqEnable,
  output logic              flagState
);
  localparam int PSC_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PRESCALE - 1);

  logic             stopN;   // active-low run bit: 1 = stopped
  logic [PSC_W-1:0] pscCnt;
  logic             preloadWr;
  logic             ctrlWr;
  logic             clearWr;
  logic             tickNow;

  assign preloadWr = regWrEn && (regAddr == PRELOAD_OFS);
  assign ctrlWr    = regWrEn && (regAddr == CTRL_OFS);
  assign clearWr   = regWrEn && (regAddr == CLEAR_OFS) && regWrData[0];
  assign runOn     = !stopN;
  assign tickNow   = runOn && (pscCnt == PSC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopN     <= 1'b1;
      irqEnable <= 1'b0;
    end else if (ctrlWr) begin
      stopN     <= regWrData[0];
      irqEnable <= regWrData[1];
    end
  end

  // Prescaler: held at zero while stopped, restarted by any preload write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pscCnt <= '0;
    else if (preloadWr || !runOn || tickNow)
      pscCnt <= '0;
    else
      pscCnt <= pscCnt + 1'b1;
  end

  // Sticky flag: a wrap takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flagState <= 1'b0;
    else if (wrapHit && irqEnable)
      flagState <= 1'b1;
    else if (clearWr)
      flagState <= 1'b0;
  end

  always_comb begin
    strobe.load     = preloadWr;
    strobe.tick     = tickNow;
    strobe.loadData = regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == PRELOAD_OFS)
      regRdData = count;
    else if (regAddr == CTRL_OFS)
      regRdData = {{(CNT_W-2){1'b0}}, irqEnable, stopN};
  end
endmodule

// File: rtl/base_tick_timer.sv
module base_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int                PRESCALE    = 4,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PRELOAD_OFS = 8'hC0,
  parameter logic [ADDR_W-1:0] CTRL_OFS    = 8'hC1,
  parameter logic [ADDR_W-1:0] CLEAR_OFS   = 8'hC2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic              regWrEn,
  output logic [CNT_W-1:0]  regRdData,
  output logic              timerIrq
);
  tmr_strobe_t      strobe;
  logic [CNT_W-1:0] countVal;
  logic             wrapHit;
  logic             runOn;
  logic             irqEnable;
  logic             flagState;

  timer_ctrl #(
    .PRESCALE   (PRESCALE),
    .ADDR_W     (ADDR_W),
    .PRELOAD_OFS(PRELOAD_OFS),
    .CTRL_OFS   (CTRL_OFS),
    .CLEAR_OFS  (CLEAR_OFS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .count    (countVal),
    .wrapHit  (wrapHit),
    .strobe   (strobe),
    .regRdData(regRdData),
    .runOn    (runOn),
    .irqEnable(irqEnable),
    .flagState(flagState)
  );

  timer_datapath i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (countVal),
    .wrapHit(wrapHit)
  );

  assign timerIrq = flagState && irqEnable;
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import tick_timer_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] PRELOAD_OFS = 8'hC0,
  parameter logic [ADDR_W-1:0] CLEAR_OFS   = 8'hC2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWrData,
  input logic              regWrEn,
  input logic [CNT_W-1:0]  count,
  input logic              runOn,
  input logic              irqEnable,
  input logic              flagState,
  input logic              timerIrq
);
  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  logic loadWr;
  logic clrWr;
  assign loadWr = regWrEn && (regAddr == PRELOAD_OFS);
  assign clrWr  = regWrEn && (regAddr == CLEAR_OFS) && regWrData[0];

  // R2: without a preload, the count only holds or moves up by one
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadWr |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  // R3: a preload write lands in the count on the next clock
  p_preload_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> count == $past(regWrData));

  // R4: stopped timer holds its count
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !loadWr) |=> $stable(count));

  // R6: the flag only rises from a wrap with interrupts enabled
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagState) |-> ($past(count) == MAX_CNT) && $past(irqEnable) && $past(runOn));

  // R7: the flag is sticky without a clear write
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagState && !clrWr) |=> flagState);

  // R8: a clear write drops the flag when no wrap is possible
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && count != MAX_CNT) |=> !flagState);

  // R9: the request output never fires while interrupts are masked
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    timerIrq |-> irqEnable && flagState);
endmodule

bind base_tick_timer timer_checker #(
  .ADDR_W     (ADDR_W),
  .PRELOAD_OFS(PRELOAD_OFS),
  .CLEAR_OFS  (CLEAR_OFS)
) i_timer_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regWrEn  (regWrEn),
  .count    (countVal),
  .runOn    (runOn),
  .irqEnable(irqEnable),
  .flagState(flagState),
  .timerIrq (timerIrq)
);

// File: tb/test_base_tick_timer.sv
module test_base_tick_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic       timerIrq;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  base_tick_timer i_base_tick_timer (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .regRdData(regRdData),
    .timerIrq (timerIrq)
  );

  typedef struct packed {
    logic [7:0]  pre;
    int unsigned waitCyc;
    logic [7:0]  expCnt;
    logic        expIrq;
  } vec_t;

  // start value, clocks after the enabling write, expected count, expected irq
  localparam vec_t VEC [10] = '{
    '{8'h00, 0,    8'h00, 1'b0},
    '{8'h00, 3,    8'h00, 1'b0},
    '{8'h00, 4,    8'h01, 1'b0},
    '{8'h10, 40,   8'h1A, 1'b0},
    '{8'hFE, 8,    8'h00, 1'b1},
    '{8'hFF, 4,    8'h00, 1'b1},
    '{8'hFF, 3,    8'hFF, 1'b0},
    '{8'h80, 1024, 8'h80, 1'b1},
    '{8'hF0, 100,  8'h09, 1'b1},
    '{8'hC8, 500,  8'h45, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; captured at the next rising edge; returns at the falling edge after it
  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic chkCount(input string req, input logic [7:0] exp);
    logic [7:0] v;
    rdReg(8'hC0, v);
    check(req, v, exp);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chkCount("R1 count", 8'h00);
    rdReg(8'hC1, v);
    check("R1 control", v, 8'h01);
    check("R1 irq", {7'd0, timerIrq}, 8'h00);
    repeat (20) @(negedge clk);
    chkCount("R4 stopped after reset", 8'h00);

    // R2 R5: table walk
    foreach (VEC[i]) begin
      wrReg(8'hC1, 8'h03);
      wrReg(8'hC2, 8'h01);
      wrReg(8'hC0, VEC[i].pre);
      wrReg(8'hC1, 8'h02);
      repeat (VEC[i].waitCyc) @(negedge clk);
      chkCount("R2/R5 table count", VEC[i].expCnt);
      check("R5/R6 table irq", {7'd0, timerIrq}, {7'd0, VEC[i].expIrq});
    end

    // R4: stop holds, level re-enable resumes
    wrReg(8'hC1, 8'h03);
    rdReg(8'hC0, held);
    repeat (40) @(negedge clk);
    chkCount("R4 hold", held);
    wrReg(8'hC1, 8'h02);
    repeat (3) @(negedge clk);
    chkCount("R4 resume not yet", held);
    @(negedge clk);
    chkCount("R4 resume step", held + 8'd1);

    // R6 R8 R9 R12: flag handling
    wrReg(8'hC1, 8'h03);
    wrReg(8'hC2, 8'h01);
    wrReg(8'hC0, 8'hFF);
    wrReg(8'hC1, 8'h02);
    repeat (4) @(negedge clk);
    check("R6 irq after wrap", {7'd0, timerIrq}, 8'h01);
    wrReg(8'hC2, 8'h00);
    check("R8 clear with zero ignored", {7'd0, timerIrq}, 8'h01);
    wrReg(8'hC2, 8'hFE);
    check("R8 clear with bit0 low ignored", {7'd0, timerIrq}, 8'h01);
    rdReg(8'hC2, v);
    check("R12 clear offset reads zero", v, 8'h00);
    rdReg(8'hC3, v);
    check("R12 unused offset reads zero", v, 8'h00);
    rdReg(8'hC1, v);
    check("R12 control readback", v, 8'h02);
    wrReg(8'hC1, 8'h00);
    check("R9 masked irq", {7'd0, timerIrq}, 8'h00);
    wrReg(8'hC1, 8'h02);
    check("R7 R9 flag kept while masked", {7'd0, timerIrq}, 8'h01);
    wrReg(8'hC2, 8'h01);
    check("R8 clear", {7'd0, timerIrq}, 8'h00);

    // R6: wrap with interrupts disabled leaves flag clear
    wrReg(8'hC1, 8'h01);
    wrReg(8'hC0, 8'hFF);
    wrReg(8'hC1, 8'h00);
    repeat (4) @(negedge clk);
    chkCount("R5 wrap while masked", 8'h00);
    wrReg(8'hC1, 8'h03);
    check("R6 no flag from masked wrap", {7'd0, timerIrq}, 8'h00);

    // R10: preload restarts prescaler, and wins over a same-clock step
    wrReg(8'hC0, 8'h00);
    wrReg(8'hC1, 8'h02);
    @(negedge clk);
    wrReg(8'hC0, 8'h50);
    repeat (3) @(negedge clk);
    chkCount("R10 restart no step yet", 8'h50);
    @(negedge clk);
    chkCount("R10 step after restart", 8'h51);
    repeat (3) @(negedge clk);
    wrReg(8'hC0, 8'hA0);
    chkCount("R10 R3 preload wins over step", 8'hA0);

    // R11: clear and wrap on the same clock
    wrReg(8'hC0, 8'hFF);
    repeat (4) @(negedge clk);
    check("R6 flag set before collision", {7'd0, timerIrq}, 8'h01);
    wrReg(8'hC0, 8'hFF);
    repeat (3) @(negedge clk);
    wrReg(8'hC2, 8'h01);
    check("R11 flag survives collision", {7'd0, timerIrq}, 8'h01);
    chkCount("R5 wrap at collision", 8'h00);
    wrReg(8'hC2, 8'h01);
    check("R8 clear after collision", {7'd0, timerIrq}, 8'h00);

    finishRun();
  end
endmodule